// File: doc/BRIEF.md
# Dual-Port Transceiver with Serial Shift Register

This block sits between two bidirectional data ports, A and B, each modelled as separate input data, output data and output enable. A 3-bit mode input picks one of eight functions. The block can act as a transceiver in either direction. It can drive an internal register onto one port. It can shift that register while showing it on one port, shift it with both ports released, or clear it.

The register loads in parallel from whichever port drives in a transceiver mode. In the shift modes it takes a serial bit into its lowest position and moves every bit one place up. Its top bit always leaves the block on a driven output. Wiring that output to the serial input of a neighbouring instance chains several blocks into a longer shift path.

Top module: `bidir_shift_port`

## Requirements
- R1: While `rst_n` is low the register is all zeros, so `q_last` is 0 and a register-to-A mode shows zero on `a_out`.
- R2: With mode 3'b000 (A to B), `b_oe` is 1, `a_oe` is 0 and `b_out` equals `a_in` in the same cycle. At the rising edge the register loads `a_in`.
- R3: With mode 3'b001 (B to A), `a_oe` is 1, `b_oe` is 0 and `a_out` equals `b_in` in the same cycle. At the rising edge the register loads `b_in`.
- R4: Mode 3'b010 drives the register onto A and mode 3'b011 drives it onto B. The other port is released and the register holds its value across edges.
- R5: Mode 3'b100 shows the register on A and mode 3'b101 shows it on B, using its value before the edge. At each rising edge, bit 0 takes `serin` and bit n takes the old bit n-1.
- R6: Mode 3'b110 releases both ports (both enables 0) while the register shifts as in R5.
- R7: Mode 3'b111 releases both ports and sets the register to zero at the rising edge.
- R8: `q_last` is always the register's top bit, in every mode. A bit presented on `serin` reaches `q_last` after WIDTH shift edges.
- R9: At most one of `a_oe` and `b_oe` is high at any time. Enables follow a mode change in the same cycle, and a released port drives zero on its output data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the register |
| mode | input | 3 | Function select, encoding in R2 to R7 |
| serin | input | 1 | Serial bit entering register bit 0 |
| a_in | input | WIDTH | Data arriving from port A |
| a_out | output | WIDTH | Data driven toward port A |
| a_oe | output | 1 | Port A drive enable |
| b_in | input | WIDTH | Data arriving from port B |
| b_out | output | WIDTH | Data driven toward port B |
| b_oe | output | 1 | Port B drive enable |
| q_last | output | 1 | Register top bit, always driven |

## Verification
A corrupted register bit shows up on `q_last` at once only if it is the top bit. Any other bit stays hidden until a register-to-port or shift-to-port mode puts it on a port, or until enough shift edges carry it to the top. The bench therefore reads the register back through a port after every load, hold, shift and clear. It also compares `q_last` at every step. This catches a wrong register value within one cycle of the mode that exposes it. Enable and pass-through faults are combinational, so they are visible in the same cycle as the mode that causes them.

// File: rtl/bsp_pkg.sv
package bsp_pkg;

  typedef enum logic [2:0] {
    M_A2B   = 3'b000,
    M_B2A   = 3'b001,
    M_R2A   = 3'b010,
    M_R2B   = 3'b011,
    M_SHA   = 3'b100,
    M_SHB   = 3'b101,
    M_SHOFF = 3'b110,
    M_CLR   = 3'b111
  } bsp_mode_e;

  typedef enum logic [1:0] {
    REG_HOLD,
    REG_LOAD,
    REG_SHIFT,
    REG_ZERO
  } reg_op_e;

  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_PEER,
    SRC_REG
  } drv_src_e;

  typedef struct packed {
    reg_op_e  op;
    logic     load_from_b;
    drv_src_e a_src;
    drv_src_e b_src;
  } bsp_ctrl_t;

endpackage

// File: rtl/bsp_mode_dec.sv
module bsp_mode_dec
  import bsp_pkg::*;
(
  input  logic [2:0] mode,
  output bsp_ctrl_t  ctrl
);

  always_comb begin
    ctrl = '{op: REG_HOLD, load_from_b: 1'b0, a_src: SRC_NONE, b_src: SRC_NONE};
    case (bsp_mode_e'(mode))
      M_A2B: begin
        ctrl.op    = REG_LOAD;
        ctrl.b_src = SRC_PEER;
      end
      M_B2A: begin
        ctrl.op          = REG_LOAD;
        ctrl.load_from_b = 1'b1;
        ctrl.a_src       = SRC_PEER;
      end
      M_R2A:   ctrl.a_src = SRC_REG;
      M_R2B:   ctrl.b_src = SRC_REG;
      M_SHA: begin
        ctrl.op    = REG_SHIFT;
        ctrl.a_src = SRC_REG;
      end
      M_SHB: begin
        ctrl.op    = REG_SHIFT;
        ctrl.b_src = SRC_REG;
      end
      M_SHOFF: ctrl.op = REG_SHIFT;
      M_CLR:   ctrl.op = REG_ZERO;
      default: ctrl.op = REG_HOLD;
    endcase
  end

endmodule

// File: rtl/bsp_shreg.sv
module bsp_shreg
  import bsp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  reg_op_e          op,
  input  logic [WIDTH-1:0] load_val,
  input  logic             serin,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] shifted;

  assign shifted[0] = serin;
  for (genvar i = 1; i < WIDTH; i++) begin : g_shift
    assign shifted[i] = q[i-1];
  end

  function automatic logic [WIDTH-1:0] next_val(
    input reg_op_e          o,
    input logic [WIDTH-1:0] cur,
    input logic [WIDTH-1:0] ld,
    input logic [WIDTH-1:0] sh
  );
    case (o)
      REG_LOAD:  return ld;
      REG_SHIFT: return sh;
      REG_ZERO:  return '0;
      default:   return cur;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= next_val(op, q, load_val, shifted);
  end

endmodule

// File: rtl/bsp_port_drv.sv
module bsp_port_drv
  import bsp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  drv_src_e         src,
  input  logic [WIDTH-1:0] peer_in,
  input  logic [WIDTH-1:0] reg_val,
  output logic [WIDTH-1:0] dout,
  output logic             oe
);

  assign oe = (src != SRC_NONE);

  always_comb begin
    case (src)
      SRC_PEER: dout = peer_in;
      SRC_REG:  dout = reg_val;
      default:  dout = '0;
    endcase
  end

endmodule

// File: rtl/bidir_shift_port.sv
module bidir_shift_port
  import bsp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode,
  input  logic             serin,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe,
  output logic             q_last
);

  localparam int MSB = WIDTH - 1;

  bsp_ctrl_t        ctrl;
  logic [WIDTH-1:0] reg_q;
  logic [WIDTH-1:0] load_val;

  bsp_mode_dec u_dec (
    .mode (mode),
    .ctrl (ctrl)
  );

  assign load_val = ctrl.load_from_b ? b_in : a_in;

  bsp_shreg #(.WIDTH(WIDTH)) u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (ctrl.op),
    .load_val (load_val),
    .serin    (serin),
    .q        (reg_q)
  );

  bsp_port_drv #(.WIDTH(WIDTH)) u_drv_a (
    .src     (ctrl.a_src),
    .peer_in (b_in),
    .reg_val (reg_q),
    .dout    (a_out),
    .oe      (a_oe)
  );

  bsp_port_drv #(.WIDTH(WIDTH)) u_drv_b (
    .src     (ctrl.b_src),
    .peer_in (a_in),
    .reg_val (reg_q),
    .dout    (b_out),
    .oe      (b_oe)
  );

  assign q_last = reg_q[MSB];

endmodule

// File: rtl/bsp_chk.sv
module bsp_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       mode,
  input logic             serin,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] b_in,
  input logic [WIDTH-1:0] a_out,
  input logic [WIDTH-1:0] b_out,
  input logic             a_oe,
  input logic             b_oe,
  input logic             q_last,
  input logic [WIDTH-1:0] reg_q
);

  logic is_shift;
  assign is_shift = (mode == 3'b100) || (mode == 3'b101) || (mode == 3'b110);

  assert_oe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({a_oe, b_oe}));

  assert_rel_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_oe |-> a_out == '0) and (!b_oe |-> b_out == '0));

  assert_a2b_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b000) |-> (b_oe && !a_oe && b_out == a_in));

  assert_a2b_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b000) |=> (reg_q == $past(a_in)));

  assert_b2a_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b001) |-> (a_oe && !b_oe && a_out == b_in));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b010 || mode == 3'b011) |=> $stable(reg_q));

  assert_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
    is_shift |=> (reg_q == {$past(reg_q[WIDTH-2:0]), $past(serin)}));

  assert_offline_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b110) |-> (!a_oe && !b_oe));

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b111) |=> (reg_q == '0));

  assert_tail_R8: assert property (@(posedge clk) disable iff (!rst_n)
    is_shift |=> (q_last == $past(reg_q[WIDTH-2])));

endmodule

bind bidir_shift_port bsp_chk #(.WIDTH(WIDTH)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .mode   (mode),
  .serin  (serin),
  .a_in   (a_in),
  .b_in   (b_in),
  .a_out  (a_out),
  .b_out  (b_out),
  .a_oe   (a_oe),
  .b_oe   (b_oe),
  .q_last (q_last),
  .reg_q  (reg_q)
);

// File: tb/sim_bidir_shift_port.sv
module sim_bidir_shift_port;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   mode = 3'b010;
  logic         serin = 1'b0;
  logic [W-1:0] a_in = '0;
  logic [W-1:0] b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic         a_oe, b_oe, q_last;

  int n_chk = 0;
  int n_fail = 0;
  logic [W-1:0] exp_q = '0;

  always #10 clk = ~clk;

  bidir_shift_port #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .serin(serin),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe), .q_last(q_last)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive at falling edge, check outputs, then cross a rising edge
  task automatic step(input logic [2:0] m, input logic s, input logic [W-1:0] a,
                      input logic [W-1:0] b, input string tag);
    logic          e_aoe, e_boe;
    logic [W-1:0]  e_aout, e_bout;
    @(negedge clk);
    mode = m; serin = s; a_in = a; b_in = b;
    #2;
    e_aoe  = (m == 3'b001) || (m == 3'b010) || (m == 3'b100);
    e_boe  = (m == 3'b000) || (m == 3'b011) || (m == 3'b101);
    e_aout = (m == 3'b001) ? b : (e_aoe ? exp_q : '0);
    e_bout = (m == 3'b000) ? a : (e_boe ? exp_q : '0);
    chk(tag, "a_oe", 32'(a_oe), 32'(e_aoe));
    chk(tag, "b_oe", 32'(b_oe), 32'(e_boe));
    chk(tag, "a_out", 32'(a_out), 32'(e_aout));
    chk(tag, "b_out", 32'(b_out), 32'(e_bout));
    chk(tag, "q_last", 32'(q_last), 32'(exp_q[W-1]));
    @(posedge clk);
    case (m)
      3'b000: exp_q = a;
      3'b001: exp_q = b;
      3'b100, 3'b101, 3'b110: exp_q = {exp_q[W-2:0], s};
      3'b111: exp_q = '0;
      default: exp_q = exp_q;
    endcase
  endtask

  task automatic t_reset;
    #3;
    chk("R1", "a_out in reset", 32'(a_out), 32'h0);
    chk("R1", "q_last in reset", 32'(q_last), 32'h0);
    @(negedge clk); rst_n = 1'b1;
    step(3'b010, 1'b0, 8'h11, 8'h22, "R1");
  endtask

  task automatic t_a2b;
    step(3'b000, 1'b0, 8'h5A, 8'hFF, "R2");
    step(3'b000, 1'b1, 8'hA7, 8'h00, "R2");
    step(3'b010, 1'b0, 8'h00, 8'h00, "R4");
  endtask

  task automatic t_b2a;
    step(3'b001, 1'b0, 8'h3C, 8'hC3, "R3");
    step(3'b011, 1'b1, 8'hFF, 8'hFF, "R4");
    step(3'b011, 1'b0, 8'h00, 8'h00, "R4");
    step(3'b010, 1'b1, 8'h0F, 8'hF0, "R4");
  endtask

  task automatic t_shift_a;
    step(3'b000, 1'b0, 8'h81, 8'h00, "R2");
    for (int i = 0; i < 5; i++) step(3'b100, i[0], 8'h00, 8'h00, "R5");
    step(3'b010, 1'b0, 8'h00, 8'h00, "R5");
  endtask

  task automatic t_shift_b;
    step(3'b001, 1'b0, 8'h00, 8'h96, "R3");
    for (int i = 0; i < 5; i++) step(3'b101, (i == 2), 8'h00, 8'h00, "R5");
    step(3'b011, 1'b0, 8'h00, 8'h00, "R5");
  endtask

  task automatic t_offline;
    step(3'b000, 1'b0, 8'hE1, 8'h00, "R2");
    for (int i = 0; i < 4; i++) step(3'b110, 1'b1, 8'hAA, 8'h55, "R6");
    step(3'b010, 1'b0, 8'h00, 8'h00, "R6");
  endtask

  task automatic t_cascade;
    logic [15:0] pat = 16'b1011_0010_1100_1101;
    step(3'b111, 1'b0, 8'h00, 8'h00, "R7");
    for (int i = 0; i < 16; i++) begin
      step(3'b110, pat[i], 8'h00, 8'h00, "R8");
      if (i >= W - 1) begin
        #1 chk("R8", "serial bit at q_last", 32'(q_last), 32'(pat[i-W+1]));
      end
    end
  endtask

  task automatic t_clear;
    step(3'b000, 1'b0, 8'hFF, 8'h00, "R2");
    step(3'b111, 1'b1, 8'hFF, 8'hFF, "R7");
    step(3'b010, 1'b0, 8'h00, 8'h00, "R7");
    step(3'b011, 1'b0, 8'h00, 8'h00, "R7");
  endtask

  task automatic t_mode_walk;
    for (int m = 0; m < 8; m++) step(3'(m), m[1], 8'h69, 8'h96, "R9");
    step(3'b010, 1'b0, 8'h00, 8'h00, "R9");
  endtask

  initial begin
    t_reset();
    t_a2b();
    t_b2a();
    t_shift_a();
    t_shift_b();
    t_offline();
    t_cascade();
    t_clear();
    t_mode_walk();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule